// File: doc/BRIEF.md
# Pipelined Flash Read Port

This block is a register window on the host side of a byte-wide flash data path. A flash read takes several cycles to return. The port hides that latency by prefetching: each host read returns the byte fetched by the access before it and, where needed, starts the next fetch. The host begins a read sequence with a read of a start register. That read only launches the first fetch. Each read of the data window then hands back the byte that is waiting and fetches the next one. A final read of a closing register hands back the last byte without launching a fetch, so the flash sees no extra read cycle.

Host writes to the data window go to the flash bus one byte per accepted access. A write to the terminate register ends the write burst and puts nothing on the flash bus. The block drives a `busy_o` output while a flash read is in flight, and the host must not issue an access while it is high. After a start read, `busy_o` also stays high for a settle gap, so status and ID bytes are never read too early. Strobe timing below the port and error correction belong to other blocks.

Top module: `fpr_pipe_port`

## Requirements
- R1: After reset, `busy_o`, `proto_err_o`, `host_rvalid_o`, `flash_re_o`, `flash_we_o` and `wr_burst_o` are all 0.
- R2: An accepted read of the start register (address 0x100) returns 0x00 and issues exactly one single-cycle `flash_re_o` strobe.
- R3: An accepted read of the data window while a byte is held returns that byte and issues one new flash read strobe. The new byte is captured RD_LAT cycles after acceptance.
- R4: An accepted read of the closing register (address 0x101) while a byte is held returns that byte and issues no flash read strobe.
- R5: Reading N bytes takes one start read, N-1 data-window reads and one closing read. The bytes come back in fetch order, and the sequence produces exactly N flash read strobes, N=1 included.
- R6: Every address from 0x000 to 0x0FF (upper address bits zero) reaches the same data register.
- R7: An accepted write to the data window drives `flash_we_o` for one cycle with the written byte on `flash_wdata_o` and sets `wr_burst_o`. `flash_we_o` and `flash_re_o` are never high together.
- R8: An accepted write to the terminate register (address 0x102) clears `wr_burst_o` and produces no `flash_we_o` pulse.
- R9: `busy_o` is high for exactly RD_LAT cycles after a data-window read that fetches, and for RD_LAT+SETTLE cycles after a start read.
- R10: A data-window or closing read with no byte held returns 0xFF, launches no fetch and sets `proto_err_o`. `proto_err_o` stays set until reset.
- R11: A request presented while `busy_o` is high is ignored: no read data, no flash strobe and no change to `proto_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host access request, taken when busy_o is low |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | ADDR_W | Host register address |
| host_wdata_i | input | DATA_W | Host write byte |
| host_rdata_o | output | DATA_W | Read data, valid with host_rvalid_o |
| host_rvalid_o | output | 1 | Read response strobe, one cycle after acceptance |
| busy_o | output | 1 | Host must hold off while high |
| proto_err_o | output | 1 | Sticky flag for a read with no byte held |
| flash_re_o | output | 1 | One-cycle flash read launch strobe |
| flash_rdata_i | input | DATA_W | Flash read byte, sampled RD_LAT cycles after acceptance |
| flash_we_o | output | 1 | One-cycle flash write strobe |
| flash_wdata_o | output | DATA_W | Flash write byte |
| wr_burst_o | output | 1 | High from the first window write until the terminate write |

## Verification
A host access is accepted on a rising edge. Read data, `host_rvalid_o`, the flash strobes and the write burst flag all change on that edge and are due one cycle later. The fetched byte is captured RD_LAT edges after acceptance, and `busy_o` falls after RD_LAT, or RD_LAT+SETTLE, cycles. The bench drives each request at a falling edge and only when `busy_o` is low. The monitor samples responses and strobes at falling edges and pops the expected byte from a queue as each one appears. Busy lengths are counted at falling edges starting with the first one after acceptance.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_RD_INIT,
    ACC_RD_DATA,
    ACC_RD_LAST,
    ACC_RD_OTHER,
    ACC_WR_DATA,
    ACC_WR_TERM,
    ACC_WR_OTHER
  } acc_e;

  function automatic logic acc_is_read(acc_e a);
    return (a == ACC_RD_INIT) || (a == ACC_RD_DATA) ||
           (a == ACC_RD_LAST) || (a == ACC_RD_OTHER);
  endfunction
endpackage

// File: rtl/fpr_decode.sv
module fpr_decode
  import fpr_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int WIN_BITS = 8,
  parameter int unsigned INIT_OFS = 'h100,
  parameter int unsigned LAST_OFS = 'h101,
  parameter int unsigned TERM_OFS = 'h102
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_e              acc_o
);
  logic in_win;
  assign in_win = (addr_i[ADDR_W-1:WIN_BITS] == '0);

  always_comb begin
    acc_o = ACC_NONE;
    if (req_i && !busy_i) begin
      if (we_i) begin
        if (in_win)                            acc_o = ACC_WR_DATA;
        else if (addr_i == ADDR_W'(TERM_OFS))  acc_o = ACC_WR_TERM;
        else                                   acc_o = ACC_WR_OTHER;
      end else begin
        if (in_win)                            acc_o = ACC_RD_DATA;
        else if (addr_i == ADDR_W'(INIT_OFS))  acc_o = ACC_RD_INIT;
        else if (addr_i == ADDR_W'(LAST_OFS))  acc_o = ACC_RD_LAST;
        else                                   acc_o = ACC_RD_OTHER;
      end
    end
  end
endmodule

// File: rtl/fpr_fetch.sv
module fpr_fetch #(
  parameter int DATA_W = 8,
  parameter int RD_LAT = 3,
  parameter int SETTLE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              launch_init_i,
  input  logic              consume_i,
  input  logic [DATA_W-1:0] flash_rdata_i,
  output logic              flash_re_o,
  output logic [DATA_W-1:0] hold_o,
  output logic              hold_vld_o,
  output logic              busy_o
);
  localparam int CNT_W = $clog2(RD_LAT + SETTLE + 1) + 1;

  logic [CNT_W-1:0]  cnt_q, gap_q;
  logic              init_q, re_q, hold_vld_q;
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      gap_q      <= '0;
      init_q     <= 1'b0;
      re_q       <= 1'b0;
      hold_vld_q <= 1'b0;
      hold_q     <= '0;
    end else begin
      re_q <= launch_i;
      if (launch_i) begin
        cnt_q      <= CNT_W'(RD_LAT);
        init_q     <= launch_init_i;
        hold_vld_q <= 1'b0;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          hold_q     <= flash_rdata_i;
          hold_vld_q <= 1'b1;
          // settle gap only follows a start read
          if (init_q) gap_q <= CNT_W'(SETTLE);
        end
      end else if (gap_q != '0) begin
        gap_q <= gap_q - 1'b1;
      end
      if (consume_i) hold_vld_q <= 1'b0;
    end
  end

  assign flash_re_o = re_q;
  assign hold_o     = hold_q;
  assign hold_vld_o = hold_vld_q;
  assign busy_o     = (cnt_q != '0) || (gap_q != '0);

  AST_RE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_re_o |=> !flash_re_o); // R2
  AST_CAPTURE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(1) && !launch_i) |=> (hold_vld_o && !busy_o == (gap_q == '0))); // R3
  AST_BUSY_AFTER_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> busy_o); // R9
endmodule

// File: rtl/fpr_resp.sv
module fpr_resp
  import fpr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_e              acc_i,
  input  logic [DATA_W-1:0] hold_i,
  input  logic              hold_vld_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              err_o
);
  logic              pull;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q, err_q;

  assign pull = (acc_i == ACC_RD_DATA) || (acc_i == ACC_RD_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= acc_is_read(acc_i);
      if (pull)                    rdata_q <= hold_vld_i ? hold_i : '1;
      else if (acc_is_read(acc_i)) rdata_q <= '0;
      if (pull && !hold_vld_i)     err_q   <= 1'b1;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign err_o    = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R10
  AST_EMPTY_PULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull && !hold_vld_i) |=> (rvalid_o && rdata_o == '1 && err_o)); // R10
endmodule

// File: rtl/fpr_wpath.sv
module fpr_wpath
  import fpr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_e              acc_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              flash_we_o,
  output logic [DATA_W-1:0] flash_wdata_o,
  output logic              burst_o
);
  logic              we_q, burst_q;
  logic [DATA_W-1:0] wd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      wd_q    <= '0;
      burst_q <= 1'b0;
    end else begin
      we_q <= (acc_i == ACC_WR_DATA);
      if (acc_i == ACC_WR_DATA) begin
        wd_q    <= wdata_i;
        burst_q <= 1'b1;
      end else if (acc_i == ACC_WR_TERM) begin
        burst_q <= 1'b0;
      end
    end
  end

  assign flash_we_o    = we_q;
  assign flash_wdata_o = wd_q;
  assign burst_o       = burst_q;

  AST_TERM_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == ACC_WR_TERM) |=> (!flash_we_o && !burst_o)); // R8
  AST_WR_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == ACC_WR_DATA) |=> (flash_we_o && burst_o && flash_wdata_o == $past(wdata_i))); // R7
endmodule

// File: rtl/fpr_pipe_port.sv
module fpr_pipe_port
  import fpr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 10,
  parameter int WIN_BITS = 8,
  parameter int RD_LAT   = 3,
  parameter int SETTLE   = 2,
  parameter int unsigned INIT_OFS = 'h100,
  parameter int unsigned LAST_OFS = 'h101,
  parameter int unsigned TERM_OFS = 'h102
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              host_rvalid_o,
  output logic              busy_o,
  output logic              proto_err_o,
  output logic              flash_re_o,
  input  logic [DATA_W-1:0] flash_rdata_i,
  output logic              flash_we_o,
  output logic [DATA_W-1:0] flash_wdata_o,
  output logic              wr_burst_o
);
  acc_e              acc;
  logic              busy, launch, launch_init, consume, hold_vld;
  logic [DATA_W-1:0] hold;

  fpr_decode #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS),
    .INIT_OFS(INIT_OFS), .LAST_OFS(LAST_OFS), .TERM_OFS(TERM_OFS)
  ) i_decode (
    .req_i(host_req_i), .we_i(host_we_i), .busy_i(busy),
    .addr_i(host_addr_i), .acc_o(acc)
  );

  assign launch_init = (acc == ACC_RD_INIT);
  assign launch      = launch_init || ((acc == ACC_RD_DATA) && hold_vld);
  assign consume     = (acc == ACC_RD_LAST) && hold_vld;

  fpr_fetch #(.DATA_W(DATA_W), .RD_LAT(RD_LAT), .SETTLE(SETTLE)) i_fetch (
    .clk_i, .rst_ni,
    .launch_i(launch), .launch_init_i(launch_init), .consume_i(consume),
    .flash_rdata_i, .flash_re_o,
    .hold_o(hold), .hold_vld_o(hold_vld), .busy_o(busy)
  );

  fpr_resp #(.DATA_W(DATA_W)) i_resp (
    .clk_i, .rst_ni, .acc_i(acc), .hold_i(hold), .hold_vld_i(hold_vld),
    .rdata_o(host_rdata_o), .rvalid_o(host_rvalid_o), .err_o(proto_err_o)
  );

  fpr_wpath #(.DATA_W(DATA_W)) i_wpath (
    .clk_i, .rst_ni, .acc_i(acc), .wdata_i(host_wdata_i),
    .flash_we_o, .flash_wdata_o, .burst_o(wr_burst_o)
  );

  assign busy_o = busy;

  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_req_i && busy_o) |=> (!host_rvalid_o && !flash_re_o && !flash_we_o)); // R11
  AST_ERR_KEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_req_i && busy_o && !proto_err_o) |=> !proto_err_o); // R11
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flash_re_o && flash_we_o)); // R7
  AST_LAST_NO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_req_i && !busy_o && !host_we_i && host_addr_i == ADDR_W'(LAST_OFS))
      |=> !flash_re_o); // R4
endmodule

// File: tb/test_fpr_pipe_port.sv
module test_fpr_pipe_port;
  localparam int RD_LAT = 3;
  localparam int SETTLE = 2;
  localparam logic [9:0] A_INIT = 10'h100;
  localparam logic [9:0] A_LAST = 10'h101;
  localparam logic [9:0] A_TERM = 10'h102;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req, we;
  logic [9:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata, f_rdata, f_wdata;
  logic       rvalid, busy, err, f_re, f_we, burst;

  always #5 clk = ~clk;

  fpr_pipe_port #(.RD_LAT(RD_LAT), .SETTLE(SETTLE)) i_fpr_pipe_port (
    .clk_i(clk), .rst_ni(rst_n),
    .host_req_i(req), .host_we_i(we), .host_addr_i(addr), .host_wdata_i(wdata),
    .host_rdata_o(rdata), .host_rvalid_o(rvalid), .busy_o(busy),
    .proto_err_o(err), .flash_re_o(f_re), .flash_rdata_i(f_rdata),
    .flash_we_o(f_we), .flash_wdata_o(f_wdata), .wr_burst_o(burst)
  );

  int n_chk = 0, n_fail = 0;
  int sc = 0, fetch_idx = 0, rv_cnt = 0, we_cnt = 0;
  bit held = 1'b0, done = 1'b0;
  logic [7:0] held_exp;
  logic [7:0] rq[$];
  string      rt[$];
  logic [7:0] wq[$];

  function automatic logic [7:0] byte_of(int k);
    return 8'(60 + k * 29);
  endfunction

  // flash model: strobe k delivers byte_of(k)
  always @(posedge clk) if (f_re) sc <= sc + 1;
  assign f_rdata = byte_of(sc - 1);

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rvalid) begin
        rv_cnt++;
        if (rq.size() == 0) check(1'b0, "R11 unexpected read data", rdata, 0);
        else begin
          logic [7:0] e;
          string t;
          e = rq.pop_front();
          t = rt.pop_front();
          check(rdata == e, t, rdata, e);
        end
      end
      if (f_we) begin
        we_cnt++;
        if (wq.size() == 0) check(1'b0, "R8 unexpected flash write", f_wdata, 0);
        else begin
          logic [7:0] e;
          e = wq.pop_front();
          check(f_wdata == e, "R7 flash write byte", f_wdata, e);
        end
      end
    end
  end

  task automatic acc(bit w, logic [9:0] a, logic [7:0] d);
    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic rd_init();
    rq.push_back(8'h00); rt.push_back("R2 start read data");
    held = 1'b1; held_exp = byte_of(fetch_idx); fetch_idx++;
    acc(1'b0, A_INIT, 8'h00);
  endtask

  task automatic rd_data(logic [9:0] a);
    if (held) begin
      rq.push_back(held_exp); rt.push_back("R3 R6 window read byte");
      held_exp = byte_of(fetch_idx); fetch_idx++;
    end else begin
      rq.push_back(8'hFF); rt.push_back("R10 empty window read");
    end
    acc(1'b0, a, 8'h00);
  endtask

  task automatic rd_last();
    if (held) begin
      rq.push_back(held_exp); rt.push_back("R4 closing read byte");
      held = 1'b0;
    end else begin
      rq.push_back(8'hFF); rt.push_back("R10 empty closing read");
    end
    acc(1'b0, A_LAST, 8'h00);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    held = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n, s0, rv0, w0;
    req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    do_reset();
    @(negedge clk);
    // R1
    check(!busy && !err, "R1 busy/err after reset", {busy, err}, 0);
    check(!rvalid && !burst, "R1 rvalid/burst after reset", {rvalid, burst}, 0);
    check(!f_re && !f_we, "R1 flash strobes after reset", {f_re, f_we}, 0);

    // R2, R9, R11: start read, then a request during busy
    rv0 = rv_cnt;
    rd_init();
    n = 0;
    req = 1'b1; we = 1'b0; addr = 10'h005;
    while (busy) begin
      n++;
      @(negedge clk);
      req = 1'b0;
    end
    req = 1'b0;
    check(n == RD_LAT + SETTLE, "R9 busy after start read", n, RD_LAT + SETTLE);
    check(rv_cnt == rv0 + 1, "R11 ignored request gave no data", rv_cnt, rv0 + 1);
    check(sc == fetch_idx, "R11 ignored request gave no strobe", sc, fetch_idx);
    check(!err, "R11 ignored request left error clear", err, 0);

    // R3, R9: data read busy length
    rd_data(10'h000);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check(n == RD_LAT, "R9 busy after window read", n, RD_LAT);

    // R6 aliasing
    rd_data(10'h037);
    rd_data(10'h0FF);
    wait_idle();
    s0 = sc;
    rd_last();
    wait_idle();
    check(sc == s0, "R4 closing read launched no fetch", sc, s0);
    check(sc == fetch_idx && sc == 4, "R5 strobes for four bytes", sc, 4);
    check(!err, "R5 no error in proper sequence", err, 0);

    // R10 empty reads
    rd_last();
    wait_idle();
    check(err, "R10 error set by empty closing read", err, 1);
    s0 = sc;
    rd_data(10'h010);
    wait_idle();
    check(sc == s0, "R10 empty window read launched no fetch", sc, s0);
    repeat (5) @(negedge clk);
    check(err, "R10 error sticky", err, 1);

    do_reset();
    @(negedge clk);
    check(!err, "R1 error cleared by reset", err, 0);

    // R7, R8 writes
    w0 = we_cnt;
    wq.push_back(8'h11);
    acc(1'b1, 10'h000, 8'h11);
    check(burst, "R7 burst set by window write", burst, 1);
    wq.push_back(8'h22);
    acc(1'b1, 10'h0AB, 8'h22);
    acc(1'b1, A_TERM, 8'h99);
    repeat (2) @(negedge clk);
    check(we_cnt == w0 + 2, "R8 terminate wrote no byte", we_cnt, w0 + 2);
    check(!burst, "R8 burst cleared by terminate", burst, 0);

    // R5 single byte: start then closing read only
    s0 = sc;
    rd_init();
    rd_last();
    wait_idle();
    check(sc == s0 + 1, "R5 one strobe for one byte", sc, s0 + 1);
    check(rq.size() == 0, "R5 all expected reads returned", rq.size(), 0);
    check(wq.size() == 0, "R7 all expected writes seen", wq.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule